// File: doc/BRIEF.md
# Second-Level TDM Demultiplexer with Bit Destuffing

This block takes a single serial line carrying four bit-interleaved tributaries in a second-level multiplex frame and recovers the four tributary bit streams. The line arrives one bit per clock. The frame has a fixed structure. A multiframe holds four subframes. Each subframe holds six blocks. Each block starts with one overhead bit, which is followed by `N_TRIB * BITS_PER_TRIB` data bits that are interleaved bit by bit across the tributaries. The block searches for the fixed alternating framing bits to find block and subframe alignment. It then takes the subframe numbering from the multiframe marker bit.

In each subframe, three repeated indicator bits say whether one tributary carries a justification (stuffed) bit in that subframe. The block decides this by majority vote. When the vote says stuffed, the block withholds the affected bit. Each tributary has its own valid strobe and data bit, and the strobe is raised only for real payload bits. A lock flag and a multiframe sync pulse report alignment status. Smoothing the gapped tributary clocks is left to downstream logic.

Top module: `tdm2_demux`

## Requirements
- R1: Each block is one overhead bit followed by data bits. Data bit k of a block (k counted from 0 after the overhead bit) belongs to tributary k mod N_TRIB, with tributary 0 first.
- R2: The overhead bits have fixed roles by block index within a subframe (0-based). Block 0 carries the multiframe bit. Blocks 1, 3 and 4 carry the indicator bits. Block 2 carries a framing bit of value 0, and block 5 carries a framing bit of value 1.
- R3: While hunting, a framing bit with the wrong value makes the position counter hold for one clock, which moves the alignment by one bit. Lock is declared on the value-1 framing bit that completes the fourth consecutive subframe with both framing bits correct, and only if a multiframe bit of 0 was seen since the last slip.
- R4: While locked, a subframe in which either framing bit is wrong counts as a miss. A correct subframe clears the count. The third consecutive miss drops lock at that subframe's value-1 framing bit, and hunting resumes.
- R5: A multiframe bit of 0 marks the subframe as subframe 0. While locked, `msync_o` pulses for one clock in the cycle after that bit.
- R6: Subframe j carries the indicators for tributary j. The block decides stuffed when at least two of the three indicator bits are 1, so a single corrupted indicator does not change the decision.
- R7: When subframe j is decided stuffed, the first tributary-j bit of block 5 in that subframe gets no valid strobe. All other tributary-j bits are delivered.
- R8: Data is delivered only while locked, with at most one valid strobe per clock. A valid strobe and its data bit appear one clock after the line bit, and the data bit equals that line bit.
- R9: After reset, `lock_o`, `valid_o` and `msync_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Line bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_i | input | 1 | Serial multiplexed line bit, one per clock |
| lock_o | output | 1 | Frame alignment acquired |
| valid_o | output | N_TRIB | Per-tributary strobe for a delivered payload bit |
| data_o | output | N_TRIB | Per-tributary recovered bit, meaningful when the strobe is high |
| msync_o | output | 1 | One-clock pulse after a multiframe-start marker while locked |

## Verification
Some properties are checked by assertions on every clock. At most one strobe is high at a time. A strobe implies lock, and the delivered bit equals the previous line bit. Lock can only rise on a line bit of 1, and the sync pulse needs lock and never lasts two clocks. Other behaviour only the bench scenarios can show: the exact frame in which lock is gained, lost and regained after an inserted bit; the majority vote under single indicator errors; and which payload bits are withheld as stuffing. The bench checks the last of these by comparing each tributary's delivered sequence against its transmitted sequence.

// File: rtl/tdm2_pkg.sv
// Shared constants for the second-level demultiplexer.
// Assumes a subframe of six blocks with overhead roles fixed by block index.
package tdm2_pkg;
    localparam int unsigned BLOCKS_PER_SUB = 6;
    localparam logic [2:0]  BLK_MFRAME = 3'd0;
    localparam logic [2:0]  BLK_IND_A  = 3'd1;
    localparam logic [2:0]  BLK_FRM_0  = 3'd2;
    localparam logic [2:0]  BLK_IND_B  = 3'd3;
    localparam logic [2:0]  BLK_IND_C  = 3'd4;
    localparam logic [2:0]  BLK_FRM_1  = 3'd5;

    typedef enum logic {
        ST_HUNT   = 1'b0,
        ST_LOCKED = 1'b1
    } align_state_t;
endpackage

// File: rtl/tdm2_position.sv
// Bit position tracker: block offset, block index, subframe index and
// tributary rotation. Holds all counters when adv is low (alignment slip).
// Assumes set_sf0 is raised only on the multiframe overhead bit.
module tdm2_position #(
    parameter int unsigned N_TRIB        = 4,
    parameter int unsigned BITS_PER_TRIB = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          adv,
    input  logic                          set_sf0,
    output logic                          ctl_o,
    output logic [2:0]                    blk_o,
    output logic [$clog2(N_TRIB)-1:0]     sf_o,
    output logic [$clog2(N_TRIB)-1:0]     tr_o,
    output logic                          first_o
);
    localparam int unsigned BLK_LEN = 1 + N_TRIB * BITS_PER_TRIB;
    localparam int unsigned OFF_W   = $clog2(BLK_LEN);
    localparam int unsigned IDX_W   = $clog2(N_TRIB);
    localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(BLK_LEN - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(N_TRIB - 1);

    logic [OFF_W-1:0] off_q;
    logic [2:0]       blk_q;
    logic [IDX_W-1:0] sf_q;
    logic [IDX_W-1:0] tr_q;

    // Advance offset, block and subframe counters once per line bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q <= '0;
            blk_q <= '0;
            sf_q  <= '0;
        end else if (adv) begin
            if (off_q == OFF_LAST) begin
                off_q <= '0;
                if (blk_q == 3'(tdm2_pkg::BLOCKS_PER_SUB - 1)) begin
                    blk_q <= '0;
                    sf_q  <= (sf_q == IDX_LAST) ? '0 : sf_q + 1'b1;
                end else begin
                    blk_q <= blk_q + 3'd1;
                end
            end else begin
                off_q <= off_q + 1'b1;
            end
            if (set_sf0) begin
                sf_q <= '0;
            end
        end
    end

    // Rotate the tributary index over the data bits of a block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tr_q <= '0;
        end else if (adv) begin
            if (off_q == '0 || tr_q == IDX_LAST) begin
                tr_q <= '0;
            end else begin
                tr_q <= tr_q + 1'b1;
            end
        end
    end

    assign ctl_o   = (off_q == '0);
    assign blk_o   = blk_q;
    assign sf_o    = sf_q;
    assign tr_o    = tr_q;
    assign first_o = (off_q != '0) && (off_q <= OFF_W'(N_TRIB));
endmodule

// File: rtl/tdm2_align.sv
// Alignment hunt and lock supervisor driven by the two framing bits.
// Assumes the slot strobes come from the position tracker for the current bit.
module tdm2_align #(
    parameter int unsigned LOCK_N = 4,
    parameter int unsigned LOSS_N = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_i,
    input  logic m_slot,
    input  logic f0_slot,
    input  logic f1_slot,
    output logic lock_o,
    output logic slip_o
);
    import tdm2_pkg::*;

    localparam int unsigned GW = $clog2(LOCK_N + 1);
    localparam int unsigned MW = $clog2(LOSS_N + 1);

    align_state_t    st_q;
    logic [GW-1:0]   good_q;
    logic [MW-1:0]   miss_q;
    logic            f0_bad_q;
    logic            m0_seen_q;
    logic            f_bad;

    assign slip_o = (st_q == ST_HUNT) && ((f0_slot && bit_i) || (f1_slot && !bit_i));
    assign f_bad  = f0_bad_q || !bit_i;

    // Track framing results and move between hunting and locked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_HUNT;
            good_q    <= '0;
            miss_q    <= '0;
            f0_bad_q  <= 1'b0;
            m0_seen_q <= 1'b0;
        end else if (st_q == ST_HUNT) begin
            if (m_slot && !bit_i) begin
                m0_seen_q <= 1'b1;
            end
            if (slip_o) begin
                good_q    <= '0;
                m0_seen_q <= 1'b0;
            end else if (f1_slot) begin
                if (good_q == GW'(LOCK_N - 1) && m0_seen_q) begin
                    st_q      <= ST_LOCKED;
                    good_q    <= '0;
                    miss_q    <= '0;
                    m0_seen_q <= 1'b0;
                end else if (good_q != GW'(LOCK_N - 1)) begin
                    good_q <= good_q + 1'b1;
                end
            end
        end else begin
            if (f0_slot) begin
                f0_bad_q <= bit_i;
            end
            if (f1_slot) begin
                if (!f_bad) begin
                    miss_q <= '0;
                end else if (miss_q == MW'(LOSS_N - 1)) begin
                    st_q   <= ST_HUNT;
                    miss_q <= '0;
                end else begin
                    miss_q <= miss_q + 1'b1;
                end
            end
        end
    end

    assign lock_o = (st_q == ST_LOCKED);
endmodule

// File: rtl/tdm2_stuff_vote.sv
// Majority vote over the three indicator bits of the current subframe.
// Assumes the count is restarted by the multiframe bit at subframe start.
module tdm2_stuff_vote (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_i,
    input  logic m_slot,
    input  logic c_slot,
    output logic stuff_o
);
    logic [1:0] ones_q;

    // Count indicator ones within the subframe.
    always_ff @(posedge clk) begin
        if (!rst_n || m_slot) begin
            ones_q <= '0;
        end else if (c_slot && bit_i && ones_q != 2'd3) begin
            ones_q <= ones_q + 2'd1;
        end
    end

    assign stuff_o = (ones_q >= 2'd2);
endmodule

// File: rtl/tdm2_demux.sv
// Top: splits the aligned line into per-tributary strobed bits and drops
// the justification bit when the subframe vote says stuffed.
// Assumes one line bit per clock with no gaps.
module tdm2_demux #(
    parameter int unsigned N_TRIB        = 4,
    parameter int unsigned BITS_PER_TRIB = 12,
    parameter int unsigned LOCK_N        = 4,
    parameter int unsigned LOSS_N        = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_i,
    output logic              lock_o,
    output logic [N_TRIB-1:0] valid_o,
    output logic [N_TRIB-1:0] data_o,
    output logic              msync_o
);
    import tdm2_pkg::*;

    localparam int unsigned IDX_W = $clog2(N_TRIB);

    logic             ctl, first, slip, locked, stuff;
    logic [2:0]       blk;
    logic [IDX_W-1:0] sf, tr;
    logic             m_slot, f0_slot, f1_slot, c_slot, drop;
    logic [N_TRIB-1:0] valid_d;

    tdm2_position #(.N_TRIB(N_TRIB), .BITS_PER_TRIB(BITS_PER_TRIB)) u_pos (
        .clk(clk), .rst_n(rst_n), .adv(!slip), .set_sf0(m_slot && !bit_i),
        .ctl_o(ctl), .blk_o(blk), .sf_o(sf), .tr_o(tr), .first_o(first)
    );

    tdm2_align #(.LOCK_N(LOCK_N), .LOSS_N(LOSS_N)) u_align (
        .clk(clk), .rst_n(rst_n), .bit_i(bit_i), .m_slot(m_slot),
        .f0_slot(f0_slot), .f1_slot(f1_slot), .lock_o(locked), .slip_o(slip)
    );

    tdm2_stuff_vote u_vote (
        .clk(clk), .rst_n(rst_n), .bit_i(bit_i), .m_slot(m_slot),
        .c_slot(c_slot), .stuff_o(stuff)
    );

    assign m_slot  = ctl && (blk == BLK_MFRAME);
    assign f0_slot = ctl && (blk == BLK_FRM_0);
    assign f1_slot = ctl && (blk == BLK_FRM_1);
    assign c_slot  = ctl && (blk == BLK_IND_A || blk == BLK_IND_B || blk == BLK_IND_C);
    assign drop    = !ctl && (blk == BLK_FRM_1) && (tr == sf) && first && stuff;

    for (genvar t = 0; t < N_TRIB; t++) begin : g_trib
        assign valid_d[t] = locked && !ctl && !drop && (tr == IDX_W'(t));

        // Register the strobe and capture the bit for this tributary.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_o[t] <= 1'b0;
                data_o[t]  <= 1'b0;
            end else begin
                valid_o[t] <= valid_d[t];
                if (valid_d[t]) begin
                    data_o[t] <= bit_i;
                end
            end
        end
    end

    // Flag the multiframe start marker while aligned.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msync_o <= 1'b0;
        end else begin
            msync_o <= locked && m_slot && !bit_i;
        end
    end

    assign lock_o = locked;
endmodule

// File: rtl/tdm2_demux_chk.sv
// Port-level properties of the demultiplexer, bound to every instance.
module tdm2_demux_chk #(
    parameter int unsigned N_TRIB = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_i,
    input logic              lock_o,
    input logic [N_TRIB-1:0] valid_o,
    input logic [N_TRIB-1:0] data_o,
    input logic              msync_o
);
    a_r8_valid_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (|valid_o) |-> lock_o);

    a_r8_one_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(valid_o));

    a_r8_data_follows_line: assert property (@(posedge clk) disable iff (!rst_n)
        (|valid_o) |-> ((data_o & valid_o) == (valid_o & {N_TRIB{$past(bit_i)}})));

    a_r3_lock_on_one: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> $past(bit_i));

    a_r5_msync_locked: assert property (@(posedge clk) disable iff (!rst_n)
        msync_o |-> lock_o);

    a_r5_msync_single: assert property (@(posedge clk) disable iff (!rst_n)
        msync_o |=> !msync_o);
endmodule

bind tdm2_demux tdm2_demux_chk #(.N_TRIB(N_TRIB)) u_chk (
    .clk(clk), .rst_n(rst_n), .bit_i(bit_i), .lock_o(lock_o),
    .valid_o(valid_o), .data_o(data_o), .msync_o(msync_o)
);

// File: tb/tdm2_demux_bench.sv
module tdm2_demux_bench;
    localparam int NT  = 4;
    localparam int BPT = 2;
    localparam int BLK = 1 + NT * BPT;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_i = 1'b0;
    logic lock_o, msync_o;
    logic [NT-1:0] valid_o, data_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit chk = 0, prev_chk = 0;
    bit model_locked = 0;
    bit prev_m0 = 0;
    int arm_sf = 3;
    int seq [NT];
    int got [NT];
    logic exp_q [NT][$];

    always #4 clk = ~clk;

    tdm2_demux #(.N_TRIB(NT), .BITS_PER_TRIB(BPT)) u_tdm2_demux (
        .clk(clk), .rst_n(rst_n), .bit_i(bit_i), .lock_o(lock_o),
        .valid_o(valid_o), .data_o(data_o), .msync_o(msync_o)
    );

    function automatic logic gen(int t, int s);
        logic [7:0] v;
        v = 8'(s * 29 + t * 71 + (s >> 2));
        return ^(v & 8'hB5);
    endfunction

    task automatic check1(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // Compare outputs produced by the previously driven bit.
    task automatic sample();
        if (prev_chk) begin
            check1("R5 msync", msync_o, prev_m0);
            check1("R8 single strobe", ($countones(valid_o) > 1), 1'b0);
            for (int t = 0; t < NT; t++) begin
                if (valid_o[t]) begin
                    check1("R8 strobe under lock", lock_o, 1'b1);
                    got[t]++;
                    if (exp_q[t].size() == 0) begin
                        check1("R7 unexpected strobe", valid_o[t], 1'b0);
                    end else begin
                        check1("R1/R6/R7 tributary data", data_o[t], exp_q[t].pop_front());
                    end
                end
            end
        end
    endtask

    task automatic send_bit(logic b, int pt, bit m0);
        sample();
        prev_chk = chk;
        prev_m0 = m0;
        bit_i = b;
        if (pt >= 0) exp_q[pt].push_back(b);
        @(negedge clk);
    endtask

    // One subframe: overhead per R2, interleave per R1, stuffing per R6/R7.
    task automatic send_sub(int k, int j, bit ones);
        bit st, er;
        int ci;
        st = !ones && ((k + j) % 3 == 0);
        er = !ones && ((k + j) % 2 == 1);
        for (int b = 0; b < 6; b++) begin
            for (int o = 0; o < BLK; o++) begin
                if (o == 0) begin
                    case (b)
                        0: send_bit(j != 0, -1, (j == 0) && chk && model_locked);
                        2: send_bit(1'b0, -1, 1'b0);
                        5: begin
                            send_bit(1'b1, -1, 1'b0);
                            if (arm_sf == j) begin
                                model_locked = 1;
                                arm_sf = -1;
                            end
                        end
                        default: begin
                            ci = (b == 1) ? 0 : (b == 3) ? 1 : 2;
                            send_bit(st ^ (er && ci == k % 3), -1, 1'b0);
                        end
                    endcase
                end else begin
                    int t;
                    t = (o - 1) % NT;
                    if (b == 5 && t == j && (o - 1) < NT && st) begin
                        send_bit(1'(k & 1), -1, 1'b0);
                    end else if (ones) begin
                        send_bit(1'b1, -1, 1'b0);
                    end else begin
                        logic v;
                        v = gen(t, seq[t]);
                        seq[t]++;
                        send_bit(v, (chk && model_locked) ? t : -1, 1'b0);
                    end
                end
            end
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        for (int t = 0; t < NT; t++) begin
            seq[t] = 0;
            got[t] = 0;
        end
        repeat (4) @(negedge clk);
        // R9: reset state
        check1("R9 lock", lock_o, 1'b0);
        check1("R9 valid", |valid_o, 1'b0);
        check1("R9 msync", msync_o, 1'b0);
        rst_n = 1'b1;
        chk = 1;

        // R3: aligned start, lock on fourth good subframe (index 3)
        for (int j = 0; j < 4; j++) begin
            send_sub(0, j, 0);
            if (j == 2) check1("R3 no lock after three subframes", lock_o, 1'b0);
        end
        check1("R3 lock after fourth subframe", lock_o, 1'b1);
        for (int k = 1; k < 6; k++)
            for (int j = 0; j < 4; j++) send_sub(k, j, 0);

        // R4: insert one bit, then all-ones payload
        chk = 0;
        send_bit(1'b1, -1, 1'b0);
        send_sub(6, 0, 1);
        send_sub(6, 1, 1);
        check1("R4 lock held after two missed subframes", lock_o, 1'b1);
        send_sub(6, 2, 1);
        check1("R4 lock lost on third missed subframe", lock_o, 1'b0);
        send_sub(6, 3, 1);
        check1("R4 hunting after loss", lock_o, 1'b0);
        // R3/R5: relock one slip later, numbering from the marker
        send_sub(7, 0, 1);
        send_sub(7, 1, 1);
        check1("R3 no relock before fourth good subframe", lock_o, 1'b0);
        send_sub(7, 2, 1);
        check1("R3 relock at marker-numbered subframe 2", lock_o, 1'b1);
        send_sub(7, 3, 1);

        chk = 1;
        for (int k = 8; k < 14; k++)
            for (int j = 0; j < 4; j++) send_sub(k, j, 0);
        chk = 0;
        send_bit(1'b0, -1, 1'b0);

        // R7: every transmitted payload bit delivered, none extra
        for (int t = 0; t < NT; t++) begin
            check1("R7 no payload left undelivered", exp_q[t].size() == 0, 1'b1);
            check1("R8 tributary delivered data", got[t] > 0, 1'b1);
        end
        done = 1;
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end
endmodule